// File: doc/BRIEF.md
# Stack-Aware Floating-Point Register Rename Unit

This block sits at the end of an in-order floating-point front end. Each cycle it takes a group of up to three ops. Every op names its two sources and its destination relative to a register stack. The block first turns each reference into an absolute register number, using a running top-of-stack pointer. Push and pop adjustments travel from lane to lane in program order. It then renames the absolute numbers onto a larger pool of physical registers. A source reads the newest mapping for its absolute register, and that includes a destination assigned by an earlier lane of the same group. A destination takes the lowest-numbered free physical register.

Every accepted op also enters an in-order retire queue. When the core retires ops from its head, the committed map and the committed stack pointer move forward, and the physical register that the destination replaced goes back to the free pool. A flush discards all speculative work. It restores the map and the stack pointer from their committed copies, empties the queue, and rebuilds the free pool from the committed map. The renamed group appears on registered outputs one cycle after it is accepted.

Top module: `stack_rename_unit`

## Requirements
- R1: After reset, no output lane is valid and the stack pointer is 0. Absolute register i maps to physical register i. Physical registers ARCH_REGS up to PHYS_REGS-1 are free, so a group is accepted at once.
- R2: Each reference is resolved as absolute = (stack pointer + relative) mod ARCH_REGS. Stack op code 2'b01 (push) decrements the pointer before the op's references are resolved. Code 2'b10 (pop) increments it after they are resolved. Codes 2'b00 and 2'b11 leave it unchanged.
- R3: Each source returns the physical register most recently assigned to its absolute register, including a destination renamed by an earlier lane of the same group.
- R4: Each accepted op with a destination receives the lowest-numbered free physical register, with lanes served in ascending order. No two in-flight destinations share a register.
- R5: A lane with in_valid and in_ready both high appears on the outputs exactly one cycle later with out_valid set and out_has_dst copied. out_pdst is 0 when the op has no destination. Lanes that are not accepted give no output.
- R6: in_ready is low when the free pool holds fewer registers than the number of valid lanes with a destination.
- R7: in_ready is low when the retire queue occupancy plus the number of valid lanes exceeds RQ_DEPTH, and in every cycle in which flush is high.
- R8: Each cycle, the number of set retire_valid bits gives how many of the oldest queued ops retire, in order. Each retirement updates the committed map and the committed pointer, and frees the replaced physical register. That register can be allocated from the next cycle on.
- R9: A flush copies the committed map and pointer into the speculative ones, empties the retire queue, and makes free exactly those physical registers that the committed map does not use. retire_valid is ignored in a flush cycle.
- R10: Pointer changes accumulate across the lanes of a group and across groups, and wrap modulo ARCH_REGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard speculative state, restore committed state |
| in_valid | input | LANES | Per-lane op valid; lane 0 is oldest |
| in_ready | output | LANES/1 | Group accepted this cycle (1 bit) |
| in_src_a | input | LANES*AW | Stack-relative first source per lane |
| in_src_b | input | LANES*AW | Stack-relative second source per lane |
| in_dst | input | LANES*AW | Stack-relative destination per lane |
| in_has_dst | input | LANES | Lane writes a destination |
| in_stk_op | input | LANES*2 | Stack adjustment per lane (00 none, 01 push, 10 pop) |
| retire_valid | input | LANES | Number of set bits = ops retiring from the head |
| out_valid | output | LANES | Renamed lane valid |
| out_has_dst | output | LANES | Renamed lane has a destination |
| out_psrc_a | output | LANES*PW | Physical first source |
| out_psrc_b | output | LANES*PW | Physical second source |
| out_pdst | output | LANES*PW | Newly allocated physical destination |

## Verification
A corrupted speculative map or stack pointer shows up on the next group that reads the affected register: a wrong out_psrc value one cycle after that group is accepted. A free pool that is too full or too empty shows up either as a duplicated or out-of-order out_pdst, or as in_ready dropping in the wrong cycle. A lost queue entry or a stale committed map stays hidden until a flush. The first group after the flush then reads the wrong source, or a register freed at retirement is reused later than the lowest-first rule says.

// File: rtl/rn_pkg.sv
// Shared constants and encodings for the stack-aware rename unit.
// Assumes the stack depth is a power of two so pointer arithmetic wraps freely.
package rn_pkg;
    localparam int DEF_LANES = 3;
    localparam int DEF_ARCH  = 8;
    localparam int DEF_PHYS  = 88;
    localparam int DEF_DEPTH = 72;

    typedef enum logic [1:0] {
        STK_NONE = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10,
        STK_RSVD = 2'b11
    } stk_op_e;
endpackage

// File: rtl/rn_free_pool.sv
// Free pool of physical registers held as a bitmap.
// Grants the lowest free registers to requesting lanes in lane order, takes back
// released registers, and rebuilds itself from a used-vector on flush.
// Assumes the caller never requests more registers than free_cnt reports.
module rn_free_pool #(
    parameter int NUM_PHYS = 88,
    parameter int NUM_ARCH = 8,
    parameter int LANES    = 3,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int FCW     = $clog2(NUM_PHYS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [LANES-1:0]    want,
    output logic [PW-1:0]       grant_id [LANES],
    input  logic [LANES-1:0]    rel_en,
    input  logic [PW-1:0]       rel_id [LANES],
    input  logic [NUM_PHYS-1:0] keep_used,
    output logic [FCW-1:0]      free_cnt
);
    logic [NUM_PHYS-1:0] free_q;
    logic [NUM_PHYS-1:0] after_alloc;
    logic [NUM_PHYS-1:0] free_nxt;

    // Pick the lowest free register per lane, removing each grant before the next lane.
    always_comb begin
        after_alloc = free_q;
        for (int l = 0; l < LANES; l++) begin
            grant_id[l] = '0;
            for (int p = NUM_PHYS - 1; p >= 0; p--) begin
                if (after_alloc[p]) grant_id[l] = PW'(p);
            end
            if (want[l]) after_alloc[grant_id[l]] = 1'b0;
        end
    end

    // Merge registers released by retirement into the post-allocation map.
    always_comb begin
        free_nxt = after_alloc;
        for (int l = 0; l < LANES; l++) begin
            if (rel_en[l]) free_nxt[rel_id[l]] = 1'b1;
        end
    end

    // Count free registers for the acceptance check.
    always_comb begin
        free_cnt = '0;
        for (int p = 0; p < NUM_PHYS; p++) free_cnt = free_cnt + FCW'(free_q[p]);
    end

    // Hold the bitmap: reset pattern, flush rebuild, or normal update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PHYS; p++) free_q[p] <= (p >= NUM_ARCH);
        end else if (flush) begin
            free_q <= ~keep_used;
        end else begin
            free_q <= free_nxt;
        end
    end
endmodule

// File: rtl/rn_retire_queue.sv
// In-order circular queue of renamed ops awaiting retirement.
// Pushes the enabled lanes compacted in lane order; pops pop_n entries from the head.
// Assumes pop_n never exceeds count and pushes never overflow DEPTH.
module rn_retire_queue #(
    parameter int DEPTH = 72,
    parameter int LANES = 3,
    parameter int EW    = 21,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LANES-1:0] push_en,
    input  logic [EW-1:0]    push_data [LANES],
    input  logic [NW-1:0]    pop_n,
    output logic [EW-1:0]    head_data [LANES],
    output logic [CW-1:0]    count
);
    logic [EW-1:0] mem [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [IW-1:0] slot [LANES];
    logic [NW-1:0] push_tot;

    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] base, input int k);
        int s;
        s = int'(base) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    // Place enabled lanes at consecutive slots behind the tail.
    always_comb begin
        push_tot = '0;
        for (int l = 0; l < LANES; l++) begin
            slot[l] = wrap_add(tail_q, int'(push_tot));
            if (push_en[l]) push_tot = push_tot + NW'(1);
        end
    end

    // Present the oldest entries for retirement.
    always_comb begin
        for (int l = 0; l < LANES; l++) head_data[l] = mem[wrap_add(head_q, l)];
    end

    // Store pushed entries.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (push_en[l]) mem[slot[l]] <= push_data[l];
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            head_q <= wrap_add(head_q, int'(pop_n));
            tail_q <= wrap_add(tail_q, int'(push_tot));
            count  <= count + CW'(push_tot) - CW'(pop_n);
        end
    end
endmodule

// File: rtl/rn_stack_map.sv
// Stack pointer plus speculative and committed absolute-to-physical maps.
// Resolves stack-relative references lane by lane, carrying pointer changes and
// earlier-lane destinations forward; applies retirements to the committed copy.
// Assumes NUM_ARCH is a power of two (pointer wraps by truncation).
module rn_stack_map #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 88,
    parameter int LANES    = 3,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [LANES-1:0]    acc_lane,
    input  logic [AW-1:0]       rel_a [LANES],
    input  logic [AW-1:0]       rel_b [LANES],
    input  logic [AW-1:0]       rel_d [LANES],
    input  logic [LANES-1:0]    has_dst,
    input  logic [1:0]          stk_op [LANES],
    input  logic [PW-1:0]       new_pdst [LANES],
    output logic [PW-1:0]       psrc_a [LANES],
    output logic [PW-1:0]       psrc_b [LANES],
    output logic [PW-1:0]       pold [LANES],
    output logic [AW-1:0]       adst [LANES],
    output logic [AW-1:0]       tos_after [LANES],
    input  logic [LANES-1:0]    ret_en,
    input  logic [LANES-1:0]    ret_has_dst,
    input  logic [AW-1:0]       ret_adst [LANES],
    input  logic [PW-1:0]       ret_pnew [LANES],
    input  logic [AW-1:0]       ret_tos [LANES],
    output logic [NUM_PHYS-1:0] commit_used
);
    logic [PW-1:0] smap_q [NUM_ARCH];
    logic [PW-1:0] cmap_q [NUM_ARCH];
    logic [AW-1:0] tos_q, ctos_q;
    logic [PW-1:0] swork [NUM_ARCH];
    logic [PW-1:0] cwork [NUM_ARCH];
    logic [AW-1:0] t_run, ct_run;

    // Rename the group in lane order over a running copy of map and pointer.
    always_comb begin
        swork = smap_q;
        t_run = tos_q;
        for (int l = 0; l < LANES; l++) begin
            if (acc_lane[l] && stk_op[l] == rn_pkg::STK_PUSH) t_run = t_run - AW'(1);
            psrc_a[l] = swork[t_run + rel_a[l]];
            psrc_b[l] = swork[t_run + rel_b[l]];
            adst[l]   = t_run + rel_d[l];
            pold[l]   = swork[adst[l]];
            if (acc_lane[l] && has_dst[l]) swork[adst[l]] = new_pdst[l];
            if (acc_lane[l] && stk_op[l] == rn_pkg::STK_POP) t_run = t_run + AW'(1);
            tos_after[l] = t_run;
        end
    end

    // Apply retiring ops to the committed map in queue order.
    always_comb begin
        cwork  = cmap_q;
        ct_run = ctos_q;
        for (int l = 0; l < LANES; l++) begin
            if (ret_en[l]) begin
                if (ret_has_dst[l]) cwork[ret_adst[l]] = ret_pnew[l];
                ct_run = ret_tos[l];
            end
        end
    end

    // Mark every physical register the committed map holds.
    always_comb begin
        commit_used = '0;
        for (int a = 0; a < NUM_ARCH; a++) commit_used[cmap_q[a]] = 1'b1;
    end

    // Update both maps and pointers; flush restores speculative from committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ARCH; a++) begin
                smap_q[a] <= PW'(a);
                cmap_q[a] <= PW'(a);
            end
            tos_q  <= '0;
            ctos_q <= '0;
        end else if (flush) begin
            smap_q <= cmap_q;
            tos_q  <= ctos_q;
        end else begin
            smap_q <= swork;
            tos_q  <= t_run;
            cmap_q <= cwork;
            ctos_q <= ct_run;
        end
    end
endmodule

// File: rtl/stack_rename_unit.sv
// Top of the stack-aware rename unit: acceptance control, lane packing, retire
// plumbing and the registered renamed-op outputs.
// Assumes retire_valid never names more ops than are queued, and that in_ready
// is used combinationally (it depends on in_valid and in_has_dst).
module stack_rename_unit
    import rn_pkg::*;
#(
    parameter int LANES     = DEF_LANES,
    parameter int ARCH_REGS = DEF_ARCH,
    parameter int PHYS_REGS = DEF_PHYS,
    parameter int RQ_DEPTH  = DEF_DEPTH,
    localparam int AW       = $clog2(ARCH_REGS),
    localparam int PW       = $clog2(PHYS_REGS),
    localparam int CW       = $clog2(RQ_DEPTH + 1),
    localparam int FCW      = $clog2(PHYS_REGS + 1),
    localparam int NW       = $clog2(LANES + 1),
    localparam int EW       = 1 + 2 * AW + 2 * PW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [LANES-1:0]    in_valid,
    output logic                in_ready,
    input  logic [LANES*AW-1:0] in_src_a,
    input  logic [LANES*AW-1:0] in_src_b,
    input  logic [LANES*AW-1:0] in_dst,
    input  logic [LANES-1:0]    in_has_dst,
    input  logic [LANES*2-1:0]  in_stk_op,
    input  logic [LANES-1:0]    retire_valid,
    output logic [LANES-1:0]    out_valid,
    output logic [LANES-1:0]    out_has_dst,
    output logic [LANES*PW-1:0] out_psrc_a,
    output logic [LANES*PW-1:0] out_psrc_b,
    output logic [LANES*PW-1:0] out_pdst
);
    logic [AW-1:0]       rel_a [LANES], rel_b [LANES], rel_d [LANES];
    logic [1:0]          stk_op [LANES];
    logic [PW-1:0]       grant [LANES], psrc_a [LANES], psrc_b [LANES], pold [LANES];
    logic [AW-1:0]       adst [LANES], tos_after [LANES];
    logic [EW-1:0]       push_data [LANES], head_data [LANES];
    logic [LANES-1:0]    acc, want, ret_en, ret_has, rel_en;
    logic [AW-1:0]       ret_adst [LANES], ret_tos [LANES];
    logic [PW-1:0]       ret_pnew [LANES], ret_pold [LANES];
    logic [NW-1:0]       need_cnt, grp_cnt, pop_n;
    logic [FCW-1:0]      free_cnt;
    logic [CW-1:0]       rq_count;
    logic [PHYS_REGS-1:0] commit_used;

    function automatic logic [NW-1:0] lane_count(input logic [LANES-1:0] v);
        logic [NW-1:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) n = n + NW'(v[i]);
        return n;
    endfunction

    // Split the flat lane buses into per-lane fields.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rel_a[l]  = in_src_a[l*AW +: AW];
            rel_b[l]  = in_src_b[l*AW +: AW];
            rel_d[l]  = in_dst[l*AW +: AW];
            stk_op[l] = in_stk_op[l*2 +: 2];
        end
    end

    // Accept the whole group only if registers and queue room both suffice.
    always_comb begin
        need_cnt = lane_count(in_valid & in_has_dst);
        grp_cnt  = lane_count(in_valid);
        in_ready = !flush && (free_cnt >= FCW'(need_cnt))
                   && ((int'(rq_count) + int'(grp_cnt)) <= RQ_DEPTH);
        acc      = in_valid & {LANES{in_ready}};
        want     = acc & in_has_dst;
    end

    // Retire count from the core, dropped during a flush.
    always_comb begin
        pop_n = flush ? '0 : lane_count(retire_valid);
        for (int l = 0; l < LANES; l++) begin
            ret_en[l] = (l < int'(pop_n));
            {ret_has[l], ret_adst[l], ret_pnew[l], ret_pold[l], ret_tos[l]} = head_data[l];
            rel_en[l] = ret_en[l] && ret_has[l];
        end
    end

    // Pack each renamed lane into a retire queue entry.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            push_data[l] = {in_has_dst[l], adst[l], in_has_dst[l] ? grant[l] : PW'(0),
                            pold[l], tos_after[l]};
        end
    end

    rn_free_pool #(.NUM_PHYS(PHYS_REGS), .NUM_ARCH(ARCH_REGS), .LANES(LANES)) u_pool (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .want(want), .grant_id(grant),
        .rel_en(rel_en), .rel_id(ret_pold),
        .keep_used(commit_used), .free_cnt(free_cnt)
    );

    rn_stack_map #(.NUM_ARCH(ARCH_REGS), .NUM_PHYS(PHYS_REGS), .LANES(LANES)) u_map (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .acc_lane(acc), .rel_a(rel_a), .rel_b(rel_b), .rel_d(rel_d),
        .has_dst(in_has_dst), .stk_op(stk_op), .new_pdst(grant),
        .psrc_a(psrc_a), .psrc_b(psrc_b), .pold(pold), .adst(adst), .tos_after(tos_after),
        .ret_en(ret_en), .ret_has_dst(ret_has), .ret_adst(ret_adst),
        .ret_pnew(ret_pnew), .ret_tos(ret_tos), .commit_used(commit_used)
    );

    rn_retire_queue #(.DEPTH(RQ_DEPTH), .LANES(LANES), .EW(EW)) u_rq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_en(acc), .push_data(push_data),
        .pop_n(pop_n), .head_data(head_data), .count(rq_count)
    );

    // Register the renamed group for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= '0;
            out_has_dst <= '0;
            out_psrc_a  <= '0;
            out_psrc_b  <= '0;
            out_pdst    <= '0;
        end else begin
            out_valid   <= acc;
            out_has_dst <= acc & in_has_dst;
            for (int l = 0; l < LANES; l++) begin
                out_psrc_a[l*PW +: PW] <= psrc_a[l];
                out_psrc_b[l*PW +: PW] <= psrc_b[l];
                out_pdst[l*PW +: PW]   <= want[l] ? grant[l] : PW'(0);
            end
        end
    end
endmodule

// File: rtl/rn_checker.sv
// Property checker for the stack-aware rename unit, attached by bind.
// Watches the ports plus the retire queue occupancy.
module rn_checker #(
    parameter int LANES    = 3,
    parameter int PW       = 7,
    parameter int NUM_PHYS = 88,
    parameter int RQ_DEPTH = 72,
    parameter int CW       = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic [LANES-1:0]    in_valid,
    input logic                in_ready,
    input logic [LANES-1:0]    out_valid,
    input logic [LANES-1:0]    out_has_dst,
    input logic [LANES*PW-1:0] out_psrc_a,
    input logic [LANES*PW-1:0] out_pdst,
    input logic [CW-1:0]       rq_count
);
    AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready) else $error("ready during flush"); // R7

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rq_count) <= RQ_DEPTH) else $error("retire queue overflow"); // R7

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_valid == $past(in_valid & {LANES{in_ready}})))
        else $error("output does not follow accepted group"); // R5

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_valid == '0)) else $error("output after flush"); // R9

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        AST_PDST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[i] && out_has_dst[i]) |-> (int'(out_pdst[i*PW +: PW]) < NUM_PHYS))
            else $error("destination outside pool"); // R4
        AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] |-> (int'(out_psrc_a[i*PW +: PW]) < NUM_PHYS))
            else $error("source outside pool"); // R3
        for (genvar j = i + 1; j < LANES; j++) begin : g_pair
            AST_PDST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[i] && out_valid[j] && out_has_dst[i] && out_has_dst[j])
                |-> (out_pdst[i*PW +: PW] != out_pdst[j*PW +: PW]))
                else $error("duplicate destination in group"); // R4
        end
    end
endmodule

bind stack_rename_unit rn_checker #(
    .LANES(LANES), .PW(PW), .NUM_PHYS(PHYS_REGS), .RQ_DEPTH(RQ_DEPTH), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_has_dst(out_has_dst),
    .out_psrc_a(out_psrc_a), .out_pdst(out_pdst),
    .rq_count(rq_count)
);

// File: tb/stack_rename_unit_tb.sv
`timescale 1ns/1ps
// Bench for the rename unit on a small pool and short queue so that both
// stall causes are reachable; expected values come from an arithmetic model.
module stack_rename_unit_tb;
    localparam int L     = 3;
    localparam int ARCH  = 8;
    localparam int PHYS  = 18;
    localparam int DEPTH = 12;
    localparam int AW    = $clog2(ARCH);
    localparam int PW    = $clog2(PHYS);

    logic clk, rst_n, flush;
    logic [L-1:0] in_valid, in_has_dst, retire_valid, out_valid, out_has_dst;
    logic in_ready;
    logic [L*AW-1:0] in_src_a, in_src_b, in_dst;
    logic [L*2-1:0] in_stk_op;
    logic [L*PW-1:0] out_psrc_a, out_psrc_b, out_pdst;

    stack_rename_unit #(.LANES(L), .ARCH_REGS(ARCH), .PHYS_REGS(PHYS), .RQ_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_has_dst(in_has_dst),
        .in_stk_op(in_stk_op), .retire_valid(retire_valid), .out_valid(out_valid),
        .out_has_dst(out_has_dst), .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
        .out_pdst(out_pdst)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct { bit hd; int ad; int pn; int po; int ta; } ent_t;
    int smap [ARCH], cmap [ARCH];
    int tos, ctos;
    bit mfree [PHYS];
    ent_t q [$];
    bit [L-1:0] e_valid;
    int e_pa [L], e_pb [L], e_pd [L];
    bit e_hd [L];
    bit [L-1:0] d_valid, d_hd;
    int d_sa [L], d_sb [L], d_dd [L], d_op [L];
    int n_chk, n_bad;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < ARCH; a++) begin smap[a] = a; cmap[a] = a; end
        tos = 0; ctos = 0;
        for (int p = 0; p < PHYS; p++) mfree[p] = (p >= ARCH);
        q.delete();
        e_valid = '0;
    endtask

    task automatic set_lane(input int l, input bit v, input int sa, input int sb,
                            input int dd, input bit hd, input int op);
        d_valid[l] = v; d_sa[l] = sa; d_sb[l] = sb; d_dd[l] = dd; d_hd[l] = hd; d_op[l] = op;
    endtask

    task automatic idle_lanes();
        for (int l = 0; l < L; l++) set_lane(l, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic check_outputs(input string tag);
        chk(out_valid == e_valid, {tag, " R5 out_valid"}, int'(out_valid), int'(e_valid));
        for (int l = 0; l < L; l++) begin
            if (e_valid[l]) begin
                chk(int'(out_psrc_a[l*PW +: PW]) == e_pa[l], {tag, " R2 R3 src_a"},
                    int'(out_psrc_a[l*PW +: PW]), e_pa[l]);
                chk(int'(out_psrc_b[l*PW +: PW]) == e_pb[l], {tag, " R2 R3 src_b"},
                    int'(out_psrc_b[l*PW +: PW]), e_pb[l]);
                chk(out_has_dst[l] == e_hd[l], {tag, " R5 has_dst"}, int'(out_has_dst[l]), int'(e_hd[l]));
                chk(int'(out_pdst[l*PW +: PW]) == e_pd[l], {tag, " R4 R8 pdst"},
                    int'(out_pdst[l*PW +: PW]), e_pd[l]);
            end
        end
    endtask

    // One clock: check last outputs, drive this group, predict ready and new state.
    task automatic cycle(input string tag, input bit fl, input int rn);
        int need, grp, fc, t, ad, pick;
        bit rdy;
        int rel [$];
        ent_t e;
        @(negedge clk);
        check_outputs(tag);
        flush = fl;
        in_valid = d_valid; in_has_dst = d_hd;
        for (int l = 0; l < L; l++) begin
            in_src_a[l*AW +: AW] = AW'(d_sa[l]);
            in_src_b[l*AW +: AW] = AW'(d_sb[l]);
            in_dst[l*AW +: AW]   = AW'(d_dd[l]);
            in_stk_op[l*2 +: 2]  = 2'(d_op[l]);
        end
        retire_valid = L'((1 << rn) - 1);
        #1;
        need = 0; grp = 0; fc = 0;
        for (int l = 0; l < L; l++) begin
            if (d_valid[l]) grp++;
            if (d_valid[l] && d_hd[l]) need++;
        end
        for (int p = 0; p < PHYS; p++) if (mfree[p]) fc++;
        rdy = !fl && (fc >= need) && (q.size() + grp <= DEPTH);
        chk(in_ready == rdy, {tag, " R6 R7 in_ready"}, int'(in_ready), int'(rdy));
        e_valid = '0;
        if (fl) begin
            for (int a = 0; a < ARCH; a++) smap[a] = cmap[a];
            tos = ctos;
            q.delete();
            for (int p = 0; p < PHYS; p++) mfree[p] = 1'b1;
            for (int a = 0; a < ARCH; a++) mfree[cmap[a]] = 1'b0;
        end else begin
            for (int k = 0; k < rn; k++) begin
                e = q.pop_front();
                if (e.hd) begin cmap[e.ad] = e.pn; rel.push_back(e.po); end
                ctos = e.ta;
            end
            if (rdy) begin
                t = tos;
                for (int l = 0; l < L; l++) begin
                    if (d_valid[l]) begin
                        if (d_op[l] == 1) t = (t + ARCH - 1) % ARCH;
                        e_pa[l] = smap[(t + d_sa[l]) % ARCH];
                        e_pb[l] = smap[(t + d_sb[l]) % ARCH];
                        ad = (t + d_dd[l]) % ARCH;
                        e_hd[l] = d_hd[l];
                        e_pd[l] = 0;
                        e.hd = d_hd[l]; e.ad = ad; e.pn = 0; e.po = smap[ad];
                        if (d_hd[l]) begin
                            pick = -1;
                            for (int p = PHYS - 1; p >= 0; p--) if (mfree[p]) pick = p;
                            mfree[pick] = 1'b0;
                            smap[ad] = pick;
                            e_pd[l] = pick;
                            e.pn = pick;
                        end
                        if (d_op[l] == 2) t = (t + 1) % ARCH;
                        e.ta = t;
                        q.push_back(e);
                        e_valid[l] = 1'b1;
                    end
                end
                tos = t;
            end
            foreach (rel[i]) mfree[rel[i]] = 1'b1;
        end
    endtask

    task automatic drain(input string tag);
        idle_lanes();
        while (q.size() > 0) cycle(tag, 0, (q.size() > L) ? L : q.size());
        cycle(tag, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        n_chk = 0; n_bad = 0;
        rst_n = 1'b0; flush = 1'b0;
        in_valid = '0; in_has_dst = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
        in_stk_op = '0; retire_valid = '0;
        idle_lanes();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // R1: identity map seen through sources
        set_lane(0, 1, 0, 5, 0, 0, 0);
        set_lane(1, 1, 7, 3, 0, 0, 0);
        cycle("R1", 0, 0);
        drain("R1");

        // R3 R2: same-group forwarding, push before resolve
        set_lane(0, 1, 1, 2, 0, 1, 0);
        set_lane(1, 1, 0, 0, 3, 0, 0);
        set_lane(2, 1, 1, 0, 0, 1, 1);
        cycle("R3", 0, 0);
        idle_lanes();
        cycle("R3", 0, 0);
        // R8: retire one, freed register 0 reused lowest-first next cycle
        cycle("R8", 0, 1);
        set_lane(0, 1, 0, 0, 4, 1, 0);
        cycle("R8", 0, 0);
        idle_lanes();
        cycle("R8", 0, 0);
        chk(int'(out_pdst[PW-1:0]) == 0, "R8 reuse of freed register", int'(out_pdst[PW-1:0]), 0);
        drain("R8");

        // R10: pointer wrap through repeated pushes and pops
        for (int k = 0; k < 10; k++) begin
            idle_lanes();
            set_lane(0, 1, 0, 1, 0, 0, 1);
            set_lane(1, 1, 2, 0, 0, 0, (k % 3 == 0) ? 2 : 1);
            cycle("R10", 0, (q.size() > L) ? L : q.size());
        end
        drain("R10");

        // R6: exhaust the free pool while the queue still has room
        for (int k = 0; k < 3; k++) begin
            for (int l = 0; l < L; l++) set_lane(l, 1, l, 0, l + k, 1, 0);
            cycle("R6", 0, 0);
        end
        set_lane(0, 1, 0, 0, 0, 1, 0);
        set_lane(1, 1, 0, 0, 1, 1, 0);
        set_lane(2, 1, 0, 0, 0, 0, 0);
        cycle("R6", 0, 0);
        chk(in_ready == 1'b0, "R6 stall on empty pool", int'(in_ready), 0);
        cycle("R6", 0, 3);
        cycle("R6", 0, 0);
        drain("R6");

        // R7: fill the queue with destination-free ops
        for (int k = 0; k < 5; k++) begin
            for (int l = 0; l < L; l++) set_lane(l, 1, l, 1, 0, 0, 0);
            cycle("R7", 0, 0);
        end
        chk(in_ready == 1'b0, "R7 stall on full queue", int'(in_ready), 0);
        drain("R7");

        // R9: speculative work discarded, committed state restored
        set_lane(0, 1, 0, 0, 0, 1, 1);
        set_lane(1, 1, 0, 0, 1, 1, 2);
        cycle("R9", 0, 0);
        idle_lanes();
        cycle("R9", 0, 1);
        cycle("R9", 1, 1);
        set_lane(0, 1, 0, 1, 2, 1, 0);
        set_lane(1, 1, 2, 3, 0, 1, 0);
        cycle("R9", 0, 0);
        drain("R9");

        // Mixed traffic sweep with occasional flushes
        for (int k = 0; k < 4000; k++) begin
            int mx;
            for (int l = 0; l < L; l++)
                set_lane(l, 1'($urandom_range(0, 1)), $urandom_range(0, ARCH - 1),
                         $urandom_range(0, ARCH - 1), $urandom_range(0, ARCH - 1),
                         1'($urandom_range(0, 1)), $urandom_range(0, 3));
            mx = (q.size() > L) ? L : q.size();
            cycle("R2 R10 sweep", ($urandom_range(0, 63) == 0), $urandom_range(0, mx));
        end
        drain("R9 sweep end");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule